// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block watches the request traffic of each rank on a DDR3-style memory channel and drives each rank's clock-enable line. A rank that has seen no pending request and no issued command for a programmable number of cycles has its clock enable dropped, which puts it in precharge power-down, and the block flags that entry for one cycle. As soon as work for a sleeping rank appears, the clock enable is raised again (fast exit only). The rank's command-allowed output stays low until the exit delay has run out.

A channel-wide self-refresh exit event starts two separate hold-off windows. The short one gates commands that can run without a locked DLL, and the long one gates commands that need it. A class tag on the command in flight selects which window applies. A minimum level time governs every transition of a clock-enable line. A mode input ties all ranks to one shared clock enable: the group then powers down only when every rank has been quiet long enough, and wakes as soon as any rank has work. All timings come from one 32-bit configuration word, counted in controller clock cycles.

Top module: `rpd_rank_pwr_ctrl`

## Requirements
- R1: While reset is high and on the cycle after, every `cke` bit is 1, every `pd_enter_req` bit is 0, and with all timing fields 0 every `cmd_ok` bit is 1.
- R2: `timing_cfg` fields: bits 31:24 idle limit, bits 23:21 power-down exit delay, bits 20:11 self-refresh exit delay for DLL-locked commands, bits 10:3 self-refresh exit delay for other commands, bits 2:0 minimum clock-enable level time. All are in clock cycles.
- R3: A rank counts as busy in a cycle when its `req_pending` bit is 1, or when `cmd_issue` is 1 with `cmd_rank` equal to its index, or when `sr_exit` is 1. With an idle limit N > 0 and sharing off, `cke` of the rank falls at the clock edge that samples its N-th consecutive non-busy cycle. `pd_enter_req` of that rank is 1 for exactly the first cycle `cke` is low.
- R4: A single busy cycle restarts the idle count from zero, including a lone `cmd_issue` strobe aimed at the rank.
- R5: An idle limit of 0 never lowers `cke` and never raises `pd_enter_req`.
- R6: With `cke_shared` = 1, no rank's `cke` falls until every rank has met the idle limit, all ranks fall together, and a busy cycle on any one rank raises every `cke`.
- R7: A rank whose `cke` is low raises it at the first edge that samples the rank busy, provided the minimum level time allows it.
- R8: After `cke` rises, `cmd_ok` of that rank stays 0 for exactly the exit-delay number of cycles, then returns to 1.
- R9: After the edge that samples `sr_exit` = 1, `cmd_ok` stays 0 for the short self-refresh delay when `cmd_needs_dll` = 0, and for the long delay when `cmd_needs_dll` = 1.
- R10: Every `cke` level, high or low, is held for at least the minimum level time before it changes. A request that arrives earlier is served at the first edge that allows it.
- R11: `cmd_ok` of a rank is 0 for every cycle its `cke` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_cfg | input | 32 | Packed timing fields (see R2) |
| cke_shared | input | 1 | 1: all ranks share a single clock enable |
| req_pending | input | NUM_RANKS | Per-rank pending-request flags |
| cmd_issue | input | 1 | A command is issued this cycle |
| cmd_rank | input | RANK_W | Target rank of the issued command |
| cmd_needs_dll | input | 1 | Class of the next command: 1 needs a locked DLL |
| sr_exit | input | 1 | One-cycle self-refresh exit event |
| cke | output | NUM_RANKS | Per-rank clock enable (registered) |
| pd_enter_req | output | NUM_RANKS | One-cycle power-down entry request |
| cmd_ok | output | NUM_RANKS | Command allowed for the given class |

## Verification
The bench aims at the off-by-one points of every counter. Two are the exact edge where `cke` falls after N quiet cycles and the last blocked cycle of each exit window. An idle counter that is one cycle late or early, or an exit timer that counts to N+1, misses the expected cycle. One command strobe in the middle of an idle run must restart the count; a design that ignored `cmd_issue` would drop `cke` three cycles early. In shared mode one rank sits idle far past the limit while the other is still busy, so a design that grouped the ranks wrongly would drop one line alone. Requests that arrive inside the minimum level time check that the wake is deferred rather than lost. The tag is switched across the two self-refresh windows to catch a swapped window.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  localparam int IDLE_W  = 8;
  localparam int XP_W    = 3;
  localparam int XSDLL_W = 10;
  localparam int XS_W    = 8;
  localparam int HOLD_W  = 3;
  localparam int CFG_W   = IDLE_W + XP_W + XSDLL_W + XS_W + HOLD_W;

  // Field order is the register layout, most significant field first.
  typedef struct packed {
    logic [IDLE_W-1:0]  idle_lim;
    logic [XP_W-1:0]    pd_exit;
    logic [XSDLL_W-1:0] sr_exit_dll;
    logic [XS_W-1:0]    sr_exit_fast;
    logic [HOLD_W-1:0]  min_level;
  } rpd_timing_t;

endpackage

// File: rtl/rpd_idle_timer.sv
module rpd_idle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic [CW-1:0] limit,
  output logic          ripe
);

  logic [CW-1:0] quiet_cnt;

  // Counts consecutive non-busy cycles, saturating at the top value.
  always_ff @(posedge clk) begin
    if (rst || busy) begin
      quiet_cnt <= '0;
    end else if (quiet_cnt != '1) begin
      quiet_cnt <= quiet_cnt + CW'(1);
    end
  end

  // The current cycle is the limit-th quiet one once limit-1 lie behind it.
  assign ripe = (limit != '0) && !busy && (quiet_cnt >= limit - CW'(1));

  p_quiet_restart_r4: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (quiet_cnt == '0));

endmodule

// File: rtl/rpd_hold_timer.sv
module rpd_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         active
);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= value;
    end else if (remain != '0) begin
      remain <= remain - W'(1);
    end
  end

  assign active = (remain != '0);

  p_window_drains_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$past(load)) |-> (remain < $past(remain)));

endmodule

// File: rtl/rpd_cke_ctrl.sv
module rpd_cke_ctrl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enter,
  input  logic          wake,
  input  logic [AW-1:0] min_hold,
  output logic          cke_q,
  output logic          pde_q,
  output logic          rise_now,
  output logic          may_flip
);

  logic [AW-1:0] age;

  assign may_flip = (age >= min_hold);
  assign rise_now = !cke_q && wake && may_flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q <= 1'b1;
      pde_q <= 1'b0;
      age   <= '1;
    end else begin
      pde_q <= 1'b0;
      if (cke_q && enter && may_flip) begin
        cke_q <= 1'b0;
        pde_q <= 1'b1;
        age   <= AW'(1);
      end else if (rise_now) begin
        cke_q <= 1'b1;
        age   <= AW'(1);
      end else if (age != '1) begin
        age <= age + AW'(1);
      end
    end
  end

  p_level_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cke_q != $past(cke_q)) |-> ($past(age) >= $past(min_hold)));

  p_pde_marks_fall_r3: assert property (@(posedge clk) disable iff (rst)
    pde_q |-> $fell(cke_q));

  p_rise_needs_work_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> $past(wake));

endmodule

// File: rtl/rpd_rank_pwr_ctrl.sv
module rpd_rank_pwr_ctrl
  import rpd_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_W-1:0]     timing_cfg,
  input  logic                 cke_shared,
  input  logic [NUM_RANKS-1:0] req_pending,
  input  logic                 cmd_issue,
  input  logic [RANK_W-1:0]    cmd_rank,
  input  logic                 cmd_needs_dll,
  input  logic                 sr_exit,
  output logic [NUM_RANKS-1:0] cke,
  output logic [NUM_RANKS-1:0] pd_enter_req,
  output logic [NUM_RANKS-1:0] cmd_ok
);

  rpd_timing_t tcfg;
  assign tcfg = rpd_timing_t'(timing_cfg);

  logic [NUM_RANKS-1:0] busy, ripe, may, rise, enter, wake, xp_active;
  logic all_ripe, all_may, any_busy;
  logic xs_active, xsdll_active;

  assign all_ripe = &ripe;
  assign all_may  = &may;
  assign any_busy = |busy;

  // Channel-wide self-refresh exit windows
  rpd_hold_timer #(.W(XS_W)) u_xs (
    .clk(clk), .rst(rst), .load(sr_exit),
    .value(tcfg.sr_exit_fast), .active(xs_active)
  );

  rpd_hold_timer #(.W(XSDLL_W)) u_xsdll (
    .clk(clk), .rst(rst), .load(sr_exit),
    .value(tcfg.sr_exit_dll), .active(xsdll_active)
  );

  for (genvar gi = 0; gi < NUM_RANKS; gi++) begin : g_rank
    assign busy[gi] = req_pending[gi] | sr_exit |
                      (cmd_issue && (cmd_rank == RANK_W'(gi)));

    // Shared mode: the group moves only when every member may move.
    assign enter[gi] = cke_shared ? (all_ripe && all_may) : ripe[gi];
    assign wake[gi]  = cke_shared ? (any_busy && all_may) : busy[gi];

    rpd_idle_timer #(.CW(IDLE_W)) u_idle (
      .clk(clk), .rst(rst), .busy(busy[gi]),
      .limit(tcfg.idle_lim), .ripe(ripe[gi])
    );

    rpd_cke_ctrl #(.AW(HOLD_W)) u_cke (
      .clk(clk), .rst(rst), .enter(enter[gi]), .wake(wake[gi]),
      .min_hold(tcfg.min_level), .cke_q(cke[gi]), .pde_q(pd_enter_req[gi]),
      .rise_now(rise[gi]), .may_flip(may[gi])
    );

    rpd_hold_timer #(.W(XP_W)) u_xp (
      .clk(clk), .rst(rst), .load(rise[gi]),
      .value(tcfg.pd_exit), .active(xp_active[gi])
    );

    assign cmd_ok[gi] = cke[gi] && !xp_active[gi] &&
                        (cmd_needs_dll ? !xsdll_active : !xs_active);

    p_xp_window_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(rise[gi]) && ($past(tcfg.pd_exit) != '0)) |-> !cmd_ok[gi]);

    p_no_entry_off_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(tcfg.idle_lim) == '0) |-> !pd_enter_req[gi]);

    p_asleep_blocks_r11: assert property (@(posedge clk) disable iff (rst)
      !cke[gi] |-> !cmd_ok[gi]);
  end

  if (NUM_RANKS > 1) begin : g_share_chk
    p_shared_lockstep_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(cke_shared) && ($past(cke[0]) == $past(cke[1]))) |-> (cke[0] == cke[1]));
  end

  p_sr_fast_window_r9: assert property (@(posedge clk) disable iff (rst)
    (sr_exit && (tcfg.sr_exit_fast != '0)) |=> xs_active);

  p_sr_dll_window_r9: assert property (@(posedge clk) disable iff (rst)
    (sr_exit && (tcfg.sr_exit_dll != '0)) |=> xsdll_active);

endmodule

// File: tb/sim_rpd_rank_pwr_ctrl.sv
module sim_rpd_rank_pwr_ctrl;

  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [31:0]   timing_cfg;
  logic          cke_shared;
  logic [NR-1:0] req_pending;
  logic          cmd_issue;
  logic [0:0]    cmd_rank;
  logic          cmd_needs_dll;
  logic          sr_exit;
  logic [NR-1:0] cke, pd_enter_req, cmd_ok;

  always #2 clk = ~clk;

  rpd_rank_pwr_ctrl #(.NUM_RANKS(NR)) u0 (
    .clk(clk), .rst(rst), .timing_cfg(timing_cfg), .cke_shared(cke_shared),
    .req_pending(req_pending), .cmd_issue(cmd_issue), .cmd_rank(cmd_rank),
    .cmd_needs_dll(cmd_needs_dll), .sr_exit(sr_exit),
    .cke(cke), .pd_enter_req(pd_enter_req), .cmd_ok(cmd_ok)
  );

  typedef struct {
    int    due;
    int    sel;   // 0 cke, 1 pd_enter_req, 2 cmd_ok
    int    rk;
    logic  val;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_cfg(int idle, int xp, int xsdll, int xs, int hold);
    return {8'(idle), 3'(xp), 10'(xsdll), 8'(xs), 3'(hold)};
  endfunction

  function automatic logic pick(int sel, int rk);
    case (sel)
      0:       return cke[rk];
      1:       return pd_enter_req[rk];
      default: return cmd_ok[rk];
    endcase
  endfunction

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int due, int sel, int rk, logic val, string tag);
    exp_t e;
    e.due = due; e.sel = sel; e.rk = rk; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops due items and compares against the ports
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      cur = sb.pop_front();
      checks++;
      if (cur.due != cyc || pick(cur.sel, cur.rk) !== cur.val) begin
        fails++;
        $display("FAIL %s sel=%0d rank=%0d cycle=%0d actual=%b expected=%b",
                 cur.tag, cur.sel, cur.rk, cyc, pick(cur.sel, cur.rk), cur.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    rst = 1'b1; timing_cfg = '0; cke_shared = 1'b0; req_pending = 2'b11;
    cmd_issue = 1'b0; cmd_rank = '0; cmd_needs_dll = 1'b0; sr_exit = 1'b0;
    tick(3);
    // R1: reset state
    c = cyc;
    for (int r = 0; r < NR; r++) begin
      expect_at(c, 0, r, 1'b1, "R1 cke after reset");
      expect_at(c, 1, r, 1'b0, "R1 no entry request in reset");
      expect_at(c, 2, r, 1'b1, "R1 commands allowed");
    end
    rst = 1'b0;
    tick(4);

    // R3 / R2 / R11: idle entry after 4 quiet cycles, rank 0 only
    timing_cfg = mk_cfg(4, 2, 0, 0, 0);
    req_pending = 2'b10;
    c = cyc;
    expect_at(c + 3, 0, 0, 1'b1, "R3 cke still high before limit");
    expect_at(c + 4, 0, 0, 1'b0, "R3 R2 cke falls on 4th quiet cycle");
    expect_at(c + 4, 1, 0, 1'b1, "R3 entry request pulse");
    expect_at(c + 4, 2, 0, 1'b0, "R11 no command while asleep");
    expect_at(c + 4, 0, 1, 1'b1, "R3 busy rank stays awake");
    expect_at(c + 5, 1, 0, 1'b0, "R3 entry request lasts one cycle");
    tick(6);
    // R7 / R8: wake and exit delay of 2
    req_pending = 2'b11;
    c = cyc;
    expect_at(c + 1, 0, 0, 1'b1, "R7 cke rises on request");
    expect_at(c + 1, 2, 0, 1'b0, "R8 first exit cycle blocked");
    expect_at(c + 2, 2, 0, 1'b0, "R8 second exit cycle blocked");
    expect_at(c + 3, 2, 0, 1'b1, "R8 commands allowed after exit delay");
    tick(5);

    // R4: one command strobe restarts the idle count
    timing_cfg = mk_cfg(4, 0, 0, 0, 0);
    req_pending = 2'b10;
    c = cyc;
    expect_at(c + 6, 0, 0, 1'b1, "R4 strobe restarted count");
    expect_at(c + 7, 0, 0, 1'b0, "R4 entry after fresh quiet run");
    tick(2);
    cmd_issue = 1'b1; cmd_rank = 1'b0;
    tick(1);
    cmd_issue = 1'b0;
    tick(5);
    req_pending = 2'b11;
    tick(9);

    // R10: minimum level time of 5 in both directions
    timing_cfg = mk_cfg(1, 0, 0, 0, 5);
    req_pending = 2'b10;
    c = cyc;
    expect_at(c + 1, 0, 0, 1'b0, "R10 entry with limit 1");
    expect_at(c + 5, 0, 0, 1'b0, "R10 low level held despite request");
    expect_at(c + 6, 0, 0, 1'b1, "R10 deferred wake served");
    tick(1);
    req_pending = 2'b11;
    tick(5);
    req_pending = 2'b10;
    expect_at(c + 10, 0, 0, 1'b1, "R10 high level held despite idle");
    expect_at(c + 11, 0, 0, 1'b0, "R10 deferred entry served");
    tick(5);
    req_pending = 2'b11;
    tick(10);

    // R5: idle limit 0 disables entry
    timing_cfg = mk_cfg(0, 0, 0, 0, 0);
    req_pending = 2'b00;
    c = cyc;
    expect_at(c + 5, 0, 0, 1'b1, "R5 rank 0 stays awake");
    expect_at(c + 10, 1, 1, 1'b0, "R5 no entry request");
    expect_at(c + 20, 0, 0, 1'b1, "R5 rank 0 awake after long idle");
    expect_at(c + 20, 0, 1, 1'b1, "R5 rank 1 awake after long idle");
    tick(21);
    req_pending = 2'b11;
    tick(2);

    // R6: shared clock enable
    timing_cfg = mk_cfg(3, 0, 0, 0, 0);
    cke_shared = 1'b1;
    req_pending = 2'b10;
    c = cyc;
    expect_at(c + 5, 0, 0, 1'b1, "R6 idle rank waits for partner");
    expect_at(c + 7, 0, 0, 1'b1, "R6 partner not yet at limit");
    expect_at(c + 8, 0, 0, 1'b0, "R6 group entry rank 0");
    expect_at(c + 8, 0, 1, 1'b0, "R6 group entry rank 1");
    tick(5);
    req_pending = 2'b00;
    tick(5);
    req_pending = 2'b10;
    c = cyc;
    expect_at(c + 1, 0, 0, 1'b1, "R6 group wake rank 0");
    expect_at(c + 1, 0, 1, 1'b1, "R6 group wake rank 1");
    tick(3);
    cke_shared = 1'b0;
    req_pending = 2'b11;
    tick(3);

    // R9: self-refresh exit windows, fast 3 and DLL 6
    timing_cfg = mk_cfg(0, 0, 6, 3, 0);
    sr_exit = 1'b1;
    c = cyc;
    tick(1);
    sr_exit = 1'b0;
    for (int j = 1; j <= 7; j++) begin
      cmd_needs_dll = (j >= 5);
      if (j < 5) expect_at(c + j, 2, 0, (j >= 4), "R9 short window for unlocked class");
      else       expect_at(c + j, 2, 1, (j >= 7), "R9 long window for locked class");
      tick(1);
    end
    cmd_needs_dll = 1'b0;
    tick(3);

    while (sb.size() > 0) tick(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule